// File: doc/BRIEF.md
# Translation Table Base Selector

This block serves the first step of a short-format page-table walk. It holds the translation-table control word and, for each lookup, turns a 32-bit virtual address into the address of the first-level descriptor. It does not fetch that descriptor. A three-bit split field in the control word divides the address space between two table base registers. Base 0 covers the low addresses and base 1 covers the high ones. Two per-base disable bits can stop the walk for either region. When the chosen region is disabled, the block reports a section translation fault and gives no fetch address.

Writes to the control word go through a mask, and the mask depends on three configuration inputs:
- the large-physical-address option,
- the security option,
- the v8 mode flag.

A lookup request is answered one clock later with the descriptor address, the base that was used, and a fault flag with its code.

Top module: `ttb_walk_select`

## Requirements
- R1: After reset the control word reads 0 and no response is valid.
- R2: With cfg_v8 high, a written value is stored unchanged.
- R3: With cfg_v8 low, cfg_large_pa high and bit 31 of the written value set, bits 21:19, 15:14 and 6:3 are cleared and every other bit is kept.
- R4: With cfg_v8 low, the R3 case not met and cfg_sec_ext high, only bits 2:0 (split N), 4 (disable 0) and 5 (disable 1) are kept.
- R5: With cfg_v8 low, the R3 case not met and cfg_sec_ext low, only bits 2:0 are kept.
- R6: Base 1 is selected when the virtual address has any bit set among its top N bits. Otherwise base 0 is selected, so with N = 0 the selection is always base 0. The response reports base 1 as rsp_base_sel = 1.
- R7: For base 1, the descriptor address is (base1 & 0xFFFFC000) | ((va >> 18) & 0x3FFC).
- R8: For base 0, the descriptor address is (base0 & ~(0x3FFF >> N)) | ((va >> 18) & 0x3FFC).
- R9: If base 0 is selected with bit 4 set, or base 1 is selected with bit 5 set, the response has rsp_fault = 1, code 5 and address 0. A response without a fault has code 0.
- R10: A response is valid exactly one cycle after a valid request, and it uses the control word as it stood in the request cycle. A write in that same cycle does not affect the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_large_pa | input | 1 | Large-physical-address option present |
| cfg_sec_ext | input | 1 | Security option present |
| cfg_v8 | input | 1 | v8 mode, stores writes unmasked |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Value to write |
| ctl_q | output | 32 | Stored control word |
| base0 | input | 32 | Table base register 0 |
| base1 | input | 32 | Table base register 1 |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address of the lookup |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 32 | First-level descriptor address, 0 on fault |
| rsp_base_sel | output | 1 | Base used, 1 for base 1 |
| rsp_fault | output | 1 | Section translation fault |
| rsp_fault_code | output | 4 | 5 on fault, 0 otherwise |

## Verification
A wrong write mask is visible on ctl_q one cycle after the write. It also shows up at the next lookup as a wrong base choice, a wrong alignment or a fault that should not occur. A wrong split or base mask gives a wrong rsp_addr or rsp_base_sel in the cycle right after the request. A lost or stuck disable bit turns a fault into an address, or an address into a fault. The response register should follow the request by exactly one cycle, so a timing slip or a response taken from the wrong cycle shows up as a missing or extra rsp_valid.

// File: rtl/ttbsel_pkg.sv
package ttbsel_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned SPLIT_W     = 3;
   localparam int unsigned CODE_W      = 4;
   localparam int unsigned IDX_SHIFT   = 18;
   localparam logic [WORD_W-1:0] LONG_CLR_MASK = 32'h0038_C078;
   localparam logic [WORD_W-1:0] SEC_KEEP_MASK = 32'h0000_0037;
   localparam logic [WORD_W-1:0] MIN_KEEP_MASK = 32'h0000_0007;
   localparam logic [WORD_W-1:0] B1_ALIGN_MASK = 32'hFFFF_C000;
   localparam logic [WORD_W-1:0] IDX_MASK      = 32'h0000_3FFC;
   localparam logic [WORD_W-1:0] B0_LOW_MASK   = 32'h0000_3FFF;
   localparam logic [CODE_W-1:0] CODE_SECTION  = 4'd5;
   localparam int unsigned BIT_EXT     = 31;
   localparam int unsigned BIT_DIS0    = 4;
   localparam int unsigned BIT_DIS1    = 5;

   typedef struct packed {
      logic              fault;
      logic              sel;
      logic [WORD_W-1:0] addr;
   } lookup_t;
endpackage

// File: rtl/ttbsel_ctl_reg.sv
module ttbsel_ctl_reg
   import ttbsel_pkg::*;
#(
   parameter int unsigned W = WORD_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_large_pa,
   input  logic         cfg_sec_ext,
   input  logic         cfg_v8,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] ctl_q
);
   localparam int unsigned EXT_POS = BIT_EXT;

   generate
      if (W != WORD_W) begin : g_bad_width
         $error("ttbsel_ctl_reg: W must equal WORD_W");
      end
   endgenerate

   logic [W-1:0] masked;

   always_comb begin
      if (cfg_v8)
         masked = wr_data;
      else if (cfg_large_pa && wr_data[EXT_POS])
         masked = wr_data & ~LONG_CLR_MASK;
      else if (cfg_sec_ext)
         masked = wr_data & SEC_KEEP_MASK;
      else
         masked = wr_data & MIN_KEEP_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_en)
         ctl_q <= masked;
   end

   a_r1_reset_clear: assert property (@(posedge clk)
      $past(!rst_n) |-> ctl_q == '0);
   a_r2_v8_raw: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && cfg_v8 |=> ctl_q == $past(wr_data));
   a_r4_short_mask: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !cfg_v8 && !(cfg_large_pa && wr_data[EXT_POS])
      |=> ctl_q[W-1:6] == '0 && !ctl_q[3]);
   a_r5_min_mask: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !cfg_v8 && !cfg_sec_ext && !(cfg_large_pa && wr_data[EXT_POS])
      |=> ctl_q[W-1:3] == '0);
endmodule

// File: rtl/ttbsel_addr_calc.sv
module ttbsel_addr_calc
   import ttbsel_pkg::*;
#(
   parameter int unsigned W  = WORD_W,
   parameter int unsigned NW = SPLIT_W
) (
   input  logic [W-1:0] ctl,
   input  logic [W-1:0] base0,
   input  logic [W-1:0] base1,
   input  logic [W-1:0] va,
   output lookup_t      res
);
   localparam logic [W-1:0] ALL_ONES = '1;

   generate
      if (NW != SPLIT_W) begin : g_bad_split
         $error("ttbsel_addr_calc: NW must equal SPLIT_W");
      end
   endgenerate

   logic [NW-1:0] n;
   logic [W-1:0]  split_mask;
   logic [W-1:0]  b0_mask;
   logic [W-1:0]  table_base;
   logic          sel;
   logic          dis;

   always_comb begin
      n          = ctl[NW-1:0];
      split_mask = (n == '0) ? '0 : ~(ALL_ONES >> n);
      b0_mask    = ~(B0_LOW_MASK >> n);
      sel        = |(va & split_mask);
      table_base = sel ? (base1 & B1_ALIGN_MASK) : (base0 & b0_mask);
      dis        = sel ? ctl[BIT_DIS1] : ctl[BIT_DIS0];
      res.sel    = sel;
      res.fault  = dis;
      res.addr   = dis ? '0 : (table_base | ((va >> IDX_SHIFT) & IDX_MASK));
   end
endmodule

// File: rtl/ttb_walk_select.sv
module ttb_walk_select
   import ttbsel_pkg::*;
#(
   parameter int unsigned ADDR_W = WORD_W,
   parameter int unsigned CW     = CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_large_pa,
   input  logic              cfg_sec_ext,
   input  logic              cfg_v8,
   input  logic              ctl_wr_en,
   input  logic [ADDR_W-1:0] ctl_wr_data,
   output logic [ADDR_W-1:0] ctl_q,
   input  logic [ADDR_W-1:0] base0,
   input  logic [ADDR_W-1:0] base1,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_va,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_base_sel,
   output logic              rsp_fault,
   output logic [CW-1:0]     rsp_fault_code
);
   generate
      if (ADDR_W != WORD_W) begin : g_bad_addr
         $error("ttb_walk_select: ADDR_W must be 32");
      end
      if (CW < 3) begin : g_bad_code
         $error("ttb_walk_select: CW too narrow for the fault code");
      end
   endgenerate

   lookup_t look;

   ttbsel_ctl_reg #(.W(ADDR_W)) i_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_large_pa (cfg_large_pa),
      .cfg_sec_ext  (cfg_sec_ext),
      .cfg_v8       (cfg_v8),
      .wr_en        (ctl_wr_en),
      .wr_data      (ctl_wr_data),
      .ctl_q        (ctl_q)
   );

   ttbsel_addr_calc #(.W(ADDR_W), .NW(SPLIT_W)) i_calc (
      .ctl   (ctl_q),
      .base0 (base0),
      .base1 (base1),
      .va    (req_va),
      .res   (look)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_addr       <= '0;
         rsp_base_sel   <= 1'b0;
         rsp_fault      <= 1'b0;
         rsp_fault_code <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr       <= look.addr;
            rsp_base_sel   <= look.sel;
            rsp_fault      <= look.fault;
            rsp_fault_code <= look.fault ? CW'(CODE_SECTION) : '0;
         end
      end
   end

   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r9_fault_form: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_fault_code == CW'(5) && rsp_addr == '0);
   a_r9_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_fault_code == '0);
   a_r6_n0_base0: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && ctl_q[2:0] == 3'd0 |=> !rsp_base_sel);
   a_r7_b1_align: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault && rsp_base_sel |-> rsp_addr[1:0] == 2'b00);
endmodule

// File: tb/test_ttb_walk_select.sv
module test_ttb_walk_select;
   localparam int CLK_P = 10;
   localparam int NV    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_large_pa = 1'b0, cfg_sec_ext = 1'b0, cfg_v8 = 1'b0;
   logic        ctl_wr_en = 1'b0;
   logic [31:0] ctl_wr_data = '0;
   logic [31:0] ctl_q;
   logic [31:0] base0 = 32'h1234_5678, base1 = 32'h8765_4321;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        rsp_valid, rsp_base_sel, rsp_fault;
   logic [31:0] rsp_addr;
   logic [3:0]  rsp_fault_code;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   ttb_walk_select i_ttb_walk_select (
      .clk(clk), .rst_n(rst_n),
      .cfg_large_pa(cfg_large_pa), .cfg_sec_ext(cfg_sec_ext), .cfg_v8(cfg_v8),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_q(ctl_q),
      .base0(base0), .base1(base1), .req_valid(req_valid), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_base_sel(rsp_base_sel),
      .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code)
   );

   // cfg = {v8, large_pa, sec}, write value, expected stored value
   typedef struct packed {
      logic [2:0]  cfg;
      logic [31:0] wdata;
      logic [31:0] exp_ctl;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{3'b000, 32'hFFFF_FFFF, 32'h0000_0007},   // R5
      '{3'b001, 32'hFFFF_FFFF, 32'h0000_0037},   // R4
      '{3'b010, 32'hFFFF_FFFF, 32'hFFC7_3F87},   // R3
      '{3'b010, 32'h7FFF_FFFF, 32'h0000_0007},   // R5
      '{3'b100, 32'h1234_5678, 32'h1234_5678},   // R2
      '{3'b001, 32'h0000_0022, 32'h0000_0022},   // R4
      '{3'b011, 32'h0000_003F, 32'h0000_0037},   // R4
      '{3'b000, 32'h0000_0000, 32'h0000_0000}    // R5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [2:0] cfg, input logic [31:0] d);
      @(negedge clk);
      {cfg_v8, cfg_large_pa, cfg_sec_ext} = cfg;
      ctl_wr_en = 1'b1; ctl_wr_data = d;
      @(negedge clk);
      ctl_wr_en = 1'b0;
   endtask

   // expected lookup from the requirement formulas: {fault, sel, addr}
   function automatic logic [33:0] model(input logic [31:0] c, input logic [31:0] va);
      logic [2:0]  n = c[2:0];
      logic [31:0] split = (n == 0) ? 32'h0 : ~(32'hFFFF_FFFF >> n);
      logic        s = |(va & split);
      logic        f = s ? c[5] : c[4];
      logic [31:0] tb = s ? (base1 & 32'hFFFF_C000) : (base0 & ~(32'h3FFF >> n));
      logic [31:0] a = f ? 32'h0 : (tb | ((va >> 18) & 32'h3FFC));
      return {f, s, a};
   endfunction

   task automatic lookup(input string req, input logic [31:0] va, input logic [33:0] exp);
      @(negedge clk);
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, {31'h0, rsp_valid}, 32'h1);
      check({req, " addr"}, rsp_addr, exp[31:0]);
      check({req, " sel"}, {31'h0, rsp_base_sel}, {31'h0, exp[32]});
      check({req, " fault"}, {31'h0, rsp_fault}, {31'h0, exp[33]});
      check({req, " code"}, {28'h0, rsp_fault_code}, exp[33] ? 32'h5 : 32'h0);
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 ctl", ctl_q, 32'h0);
      check("R1 valid", {31'h0, rsp_valid}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         wr_ctl(VECS[i].cfg, VECS[i].wdata);
         check("R2-R5 mask", ctl_q, VECS[i].exp_ctl);
         lookup("R6 R7 R8 table", 32'hC123_4567, model(VECS[i].exp_ctl, 32'hC123_4567));
         lookup("R6 R7 R8 table low", 32'h0123_4567, model(VECS[i].exp_ctl, 32'h0123_4567));
      end

      // R8 with N = 0, hand value
      wr_ctl(3'b000, 32'h0);
      lookup("R8 n0", 32'hABCD_E123, {2'b00, 32'h1234_6AF0});
      // R6 / R8 with N = 2, disable 1 set
      wr_ctl(3'b001, 32'h22);
      lookup("R8 n2 base0", 32'h2000_0000, {2'b00, 32'h1234_5800});
      lookup("R9 base1 disabled", 32'hC000_0000, {2'b11, 32'h0});
      // R7 with N = 7
      wr_ctl(3'b000, 32'h7);
      lookup("R7 n7 base1", 32'h0200_0000, {2'b01, 32'h8765_4000 | 32'h0000_0080});
      lookup("R6 n7 base0", 32'h01FF_FFFF, model(32'h7, 32'h01FF_FFFF));
      // R2 v8 keeps disable bits even with the extended bit
      wr_ctl(3'b110, 32'h8000_0010);
      check("R2 v8 raw", ctl_q, 32'h8000_0010);
      lookup("R9 v8 base0 disabled", 32'h0000_1000, {2'b10, 32'h0});
      // R3 clears the disable bits in the long format
      wr_ctl(3'b010, 32'h8000_0030);
      check("R3 long clears", ctl_q, 32'h8000_0000);
      // R10 write in the request cycle does not affect the lookup
      wr_ctl(3'b001, 32'h10);
      @(negedge clk);
      req_valid = 1'b1; req_va = 32'h0; ctl_wr_en = 1'b1; ctl_wr_data = 32'h0;
      @(negedge clk);
      req_valid = 1'b0; ctl_wr_en = 1'b0;
      check("R10 old ctl fault", {31'h0, rsp_fault}, 32'h1);
      check("R10 new ctl", ctl_q, 32'h0);
      @(negedge clk);
      check("R10 valid drops", {31'h0, rsp_valid}, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule